// File: doc/BRIEF.md
# Floating-Point Square Root Unit

This unit takes one IEEE-754 operand and returns its square root. The `prec` input picks the format: 0 for single precision, with the operand in the low 32 bits, and 1 for double precision. Denormal operands are flushed to a signed zero. The unit first sorts the operand into one of five classes: zero, normal, infinity, quiet NaN or signaling NaN. A positive normal operand goes through a restoring bit-serial square-root recurrence that retires several root bits per clock. The root is then rounded to nearest-even. Every other class gets a fixed special-case result.

The host pulses `start` while the unit is idle. The unit is busy for a fixed number of cycles, and that number depends only on the precision. It then pulses `done` together with:

- the result;
- a destination write enable, which stays low when an exception occurred;
- the cause bits of the operation;
- a trap request.

Sticky flags collect the cause bits until they are cleared from outside. A separate registered decoder compares a 16-bit instruction word against the single opcode of this operation and returns the register index it carries.

Top module: `fsqrt_unit`

## Requirements
- R1: With `prec`=0, only `operand[31:0]` is used and `result[63:32]` is zero. With `prec`=1, the full 64-bit operand and result are used.
- R2: A positive normal operand yields its square root rounded to nearest-even. The cause code is 2'b01 (inexact) when the guard bit or the final remainder is nonzero, and 2'b00 otherwise. The write enable is high.
- R3: +0 and -0 pass through unchanged with cause 2'b00 and write enable high. A denormal operand is treated as a zero of the same sign, giving +0 or -0.
- R4: +infinity passes through unchanged with no exception. -infinity and any negative normal operand raise invalid operation.
- R5: A NaN whose top fraction bit is 0 is quiet. It passes through unchanged with cause 2'b00 and write enable high. A NaN whose top fraction bit is 1 is signaling and raises invalid operation.
- R6: Invalid operation gives cause 2'b10 and keeps `wr_en` low. The result is 0x7FBFFFFF in single precision and 0x7FF7FFFFFFFFFFFF in double precision.
- R7: The `cause` output is cleared on the clock edge that accepts `start`. It stays zero while busy and holds the final code from `done` until the next accepted start. Bit 1 is invalid and bit 0 is inexact.
- R8: `flags` is the OR of all cause codes since the last cycle in which `flag_clr` was high. `flag_clr` clears it to zero, but a cause produced on the same edge is still ORed in.
- R9: `trap` pulses with `done` whenever `inexact_en` was high at the accepted start, whether or not an exception occurred. Otherwise it stays low.
- R10: Counting from the edge that accepts `start`, `done` goes high 9 cycles later for single precision and 22 cycles later for double precision, for every operand class. `done` is a one-cycle pulse. `busy` is high from the accepting edge until `done`. A `start` that arrives while busy is ignored.
- R11: One cycle after `instr` is presented, `op_hit` is high exactly when `instr[15:12]`=4'hF and `instr[7:0]`=8'h6D. `op_reg` returns `instr[11:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| prec | input | 1 | 0 single precision, 1 double precision |
| operand | input | 64 | Source value (single in bits 31:0) |
| inexact_en | input | 1 | Inexact trap enable, sampled at start |
| flag_clr | input | 1 | Clear sticky flags |
| instr | input | 16 | Instruction word to match |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Square root or special value |
| wr_en | output | 1 | Destination write enable, pulsed with done |
| cause | output | 2 | Cause of last operation {invalid, inexact} |
| flags | output | 2 | Sticky flags {invalid, inexact} |
| trap | output | 1 | Trap request, pulsed with done |
| op_hit | output | 1 | Instruction matches the square-root opcode |
| op_reg | output | 4 | Register index from the instruction |

## Verification
The assertions check the following on every cycle:

- `done` lasts a single cycle.
- An invalid outcome never asserts the write enable.
- `trap` appears only alongside `done`.
- `cause` is zero while busy.
- `flags` only gain bits unless cleared, and always contain the cause just reported.
- In the recurrence, the partial remainder stays within twice the partial root.

Only the bench scenarios can show the rest:

- the rounded root values for odd and even exponents;
- the fixed result for each operand class in both precisions;
- the exact 9- and 22-cycle latencies;
- a start ignored while busy;
- the opcode decode.

// File: rtl/fsqrt_pkg.sv
package fsqrt_pkg;
  typedef enum logic [2:0] {
    CL_ZERO,
    CL_NORM,
    CL_INF,
    CL_QNAN,
    CL_SNAN
  } op_class_e;

  localparam int SP_FRAC = 23;
  localparam int SP_EXP  = 8;
  localparam int DP_FRAC = 52;
  localparam int DP_EXP  = 11;

  localparam logic [63:0] SP_DEF_NAN = 64'h0000_0000_7FBF_FFFF;
  localparam logic [63:0] DP_DEF_NAN = 64'h7FF7_FFFF_FFFF_FFFF;
endpackage

// File: rtl/fsqrt_classify.sv
module fsqrt_classify
  import fsqrt_pkg::*;
(
  input  logic                prec,
  input  logic [63:0]         operand,
  output op_class_e           cls,
  output logic                sgn,
  output logic [DP_EXP-1:0]   bexp,
  output logic [DP_FRAC:0]    mant_al,
  output logic [63:0]         pass_v
);
  logic       exp_ones;
  logic       exp_zero;
  logic       frac_zero;
  logic       frac_top;

  always_comb begin
    if (prec) begin
      sgn       = operand[63];
      bexp      = operand[62:52];
      mant_al   = {1'b1, operand[51:0]};
      exp_ones  = &operand[62:52];
      exp_zero  = ~|operand[62:52];
      frac_zero = ~|operand[51:0];
      frac_top  = operand[51];
    end else begin
      sgn       = operand[31];
      bexp      = {3'b000, operand[30:23]};
      mant_al   = {1'b1, operand[22:0], 29'b0};
      exp_ones  = &operand[30:23];
      exp_zero  = ~|operand[30:23];
      frac_zero = ~|operand[22:0];
      frac_top  = operand[22];
    end

    if (exp_zero)       cls = CL_ZERO;
    else if (!exp_ones) cls = CL_NORM;
    else if (frac_zero) cls = CL_INF;
    else if (frac_top)  cls = CL_SNAN;
    else                cls = CL_QNAN;

    if (cls == CL_ZERO)
      pass_v = prec ? {sgn, 63'b0} : {32'b0, sgn, 31'b0};
    else
      pass_v = prec ? operand : {32'b0, operand[31:0]};
  end
endmodule

// File: rtl/fsqrt_core.sv
module fsqrt_core #(
  parameter int QW  = 54,
  parameter int SPC = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic [2*QW-1:0]            rad,
  input  logic [$clog2(QW+1)-1:0]    nsteps,
  output logic [QW-1:0]              root,
  output logic                       rem_nz
);
  localparam int RW = QW + 3;
  localparam int SW = $clog2(QW+1);

  logic [2*QW-1:0] rad_q, rd;
  logic [RW-1:0]   rem_q, r, trial;
  logic [QW-1:0]   root_q, q;
  logic [SW-1:0]   left_q, l;

  always_comb begin
    r     = rem_q;
    q     = root_q;
    rd    = rad_q;
    l     = left_q;
    trial = '0;
    for (int s = 0; s < SPC; s++) begin
      if (l != '0) begin
        r     = {r[RW-3:0], rd[2*QW-1 -: 2]};
        rd    = {rd[2*QW-3:0], 2'b00};
        trial = {1'b0, q, 2'b01};
        if (r >= trial) begin
          r = r - trial;
          q = {q[QW-2:0], 1'b1};
        end else begin
          q = {q[QW-2:0], 1'b0};
        end
        l = l - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rad_q  <= '0;
      rem_q  <= '0;
      root_q <= '0;
      left_q <= '0;
    end else if (load) begin
      rad_q  <= rad;
      rem_q  <= '0;
      root_q <= '0;
      left_q <= nsteps;
    end else begin
      rad_q  <= rd;
      rem_q  <= r;
      root_q <= q;
      left_q <= l;
    end
  end

  assign root   = root_q;
  assign rem_nz = |rem_q;

  // R2
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rem_q <= {2'b00, root_q, 1'b0});
endmodule

// File: rtl/fsqrt_round.sv
module fsqrt_round
  import fsqrt_pkg::*;
(
  input  logic              prec,
  input  logic [DP_EXP-1:0] rexp,
  input  logic [DP_FRAC+1:0] root,
  input  logic              rem_nz,
  output logic [63:0]       value,
  output logic              inexact
);
  logic        lsb, up;
  logic [30:0] sp_sum;
  logic [62:0] dp_sum;

  always_comb begin
    lsb     = root[1];
    up      = root[0] & (rem_nz | lsb);
    inexact = root[0] | rem_nz;
    sp_sum  = {rexp[SP_EXP-1:0], root[SP_FRAC:1]} + {30'b0, up};
    dp_sum  = {rexp, root[DP_FRAC:1]} + {62'b0, up};
    value   = prec ? {1'b0, dp_sum} : {32'b0, 1'b0, sp_sum};
  end
endmodule

// File: rtl/fsqrt_unit.sv
module fsqrt_unit
  import fsqrt_pkg::*;
#(
  parameter int LAT_SP = 9,
  parameter int LAT_DP = 22,
  parameter int SPC    = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        prec,
  input  logic [63:0] operand,
  input  logic        inexact_en,
  input  logic        flag_clr,
  input  logic [15:0] instr,
  output logic        busy,
  output logic        done,
  output logic [63:0] result,
  output logic        wr_en,
  output logic [1:0]  cause,
  output logic [1:0]  flags,
  output logic        trap,
  output logic        op_hit,
  output logic [3:0]  op_reg
);
  localparam int QW = DP_FRAC + 2;
  localparam int SW = $clog2(QW+1);
  localparam int CW = $clog2(LAT_DP+1);
  localparam int RADW = 2*QW - (DP_FRAC+1);

  op_class_e         cls, cls_q;
  logic              sgn, sign_q, prec_q, ien_q;
  logic [DP_EXP-1:0] bexp, rexp_q;
  logic [DP_FRAC:0]  mant_al;
  logic [63:0]       pass_v, pass_q, rnd_val, def_nan;
  logic [DP_EXP:0]   exp_sum;
  logic [2*QW-1:0]   rad;
  logic [SW-1:0]     nsteps;
  logic [QW-1:0]     root;
  logic              rem_nz, rnd_inx;
  logic [CW-1:0]     cnt, lat_sel;
  logic              accept, finish, inv, norm_pos;
  logic [1:0]        new_cause;

  fsqrt_classify u_cls (
    .prec(prec), .operand(operand), .cls(cls), .sgn(sgn),
    .bexp(bexp), .mant_al(mant_al), .pass_v(pass_v)
  );

  assign accept  = start & ~busy;
  assign rad     = {mant_al, {RADW{1'b0}}} >> bexp[0];
  assign nsteps  = prec ? SW'(QW) : SW'(SP_FRAC + 2);
  assign exp_sum = {1'b0, bexp} + (prec ? (DP_EXP+1)'(1023) : (DP_EXP+1)'(127));

  fsqrt_core #(.QW(QW), .SPC(SPC)) u_core (
    .clk(clk), .rst(rst), .load(accept), .rad(rad), .nsteps(nsteps),
    .root(root), .rem_nz(rem_nz)
  );

  fsqrt_round u_rnd (
    .prec(prec_q), .rexp(rexp_q), .root(root), .rem_nz(rem_nz),
    .value(rnd_val), .inexact(rnd_inx)
  );

  always_comb begin
    lat_sel   = prec_q ? CW'(LAT_DP) : CW'(LAT_SP);
    finish    = busy && (cnt == lat_sel);
    norm_pos  = (cls_q == CL_NORM) && !sign_q;
    inv       = (cls_q == CL_SNAN) ||
                (sign_q && ((cls_q == CL_NORM) || (cls_q == CL_INF)));
    new_cause = inv ? 2'b10 : (norm_pos ? {1'b0, rnd_inx} : 2'b00);
    def_nan   = prec_q ? DP_DEF_NAN : SP_DEF_NAN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
      wr_en  <= 1'b0;
      trap   <= 1'b0;
      cause  <= 2'b00;
      result <= '0;
      prec_q <= 1'b0;
      ien_q  <= 1'b0;
      cls_q  <= CL_ZERO;
      sign_q <= 1'b0;
      rexp_q <= '0;
      pass_q <= '0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      trap  <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        cnt    <= CW'(1);
        cause  <= 2'b00;
        prec_q <= prec;
        ien_q  <= inexact_en;
        cls_q  <= cls;
        sign_q <= sgn;
        rexp_q <= exp_sum[DP_EXP:1];
        pass_q <= pass_v;
      end else if (finish) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        wr_en  <= ~inv;
        trap   <= ien_q;
        cause  <= new_cause;
        result <= inv ? def_nan : (norm_pos ? rnd_val : pass_q);
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      flags <= 2'b00;
    else
      flags <= (flag_clr ? 2'b00 : flags) | (finish ? new_cause : 2'b00);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_hit <= 1'b0;
      op_reg <= 4'h0;
    end else begin
      op_hit <= (instr[15:12] == 4'hF) && (instr[7:0] == 8'h6D);
      op_reg <= instr[11:8];
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R6
  inv_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (done && cause[1]) |-> !wr_en);
  // R9
  trap_done_chk: assert property (@(posedge clk) disable iff (rst)
    trap |-> done);
  // R7
  cause_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cause == 2'b00));
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !flag_clr |=> ((flags & $past(flags)) == $past(flags)));
  // R8
  flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ((flags & cause) == cause));
endmodule

// File: tb/sim_fsqrt_unit.sv
module sim_fsqrt_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        prec = 1'b0;
  logic [63:0] operand = '0;
  logic        inexact_en = 1'b0;
  logic        flag_clr = 1'b0;
  logic [15:0] instr = '0;
  logic        busy, done, wr_en, trap, op_hit;
  logic [63:0] result;
  logic [1:0]  cause, flags;
  logic [3:0]  op_reg;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    logic [63:0] res;
    logic        wr;
    logic [1:0]  cs;
    logic        tr;
    int          lat;
    int          st;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  fsqrt_unit u0 (
    .clk(clk), .rst(rst), .start(start), .prec(prec), .operand(operand),
    .inexact_en(inexact_en), .flag_clr(flag_clr), .instr(instr),
    .busy(busy), .done(done), .result(result), .wr_en(wr_en),
    .cause(cause), .flags(flags), .trap(trap), .op_hit(op_hit), .op_reg(op_reg)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  // monitor: pops expected items on each done pulse
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(result == e.res, {e.tag, " result"}, result, e.res);
        chk(wr_en == e.wr, {e.tag, " wr_en"}, 64'(wr_en), 64'(e.wr));
        chk(cause == e.cs, {e.tag, " cause (R7)"}, 64'(cause), 64'(e.cs));
        chk(trap == e.tr, {e.tag, " trap (R9)"}, 64'(trap), 64'(e.tr));
        chk((cyc - e.st - 1) == e.lat, {e.tag, " latency (R10)"},
            64'(cyc - e.st - 1), 64'(e.lat));
      end
    end
  end

  task automatic run_op(input logic p, input logic [63:0] op, input logic ien,
                        input logic [63:0] er, input logic ew,
                        input logic [1:0] ec, input string tag);
    exp_t e;
    @(negedge clk);
    prec = p; operand = op; inexact_en = ien; start = 1'b1;
    e.res = er; e.wr = ew; e.cs = ec; e.tr = ien;
    e.lat = p ? 22 : 9; e.st = cyc; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    do @(negedge clk); while (exp_q.size() != 0);
  endtask

  function automatic logic [63:0] dsqrt(input logic [63:0] x);
    return $realtobits($sqrt($bitstoreal(x)));
  endfunction

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R10, R8, R7)
    chk(!busy && !done && !wr_en && !trap, "R10 reset outputs",
        64'({busy, done, wr_en, trap}), 64'd0);
    chk(flags == 2'b00 && cause == 2'b00, "R8 reset flags/cause",
        64'({flags, cause}), 64'd0);

    // R2 single precision normals, odd and even exponents
    run_op(0, 64'h0000_0000_4080_0000, 0, 64'h4000_0000, 1, 2'b00, "R2 sp sqrt 4");
    chk(flags == 2'b00, "R8 flags after exact", 64'(flags), 64'd0);
    run_op(0, 64'h0000_0000_4000_0000, 0, 64'h3FB5_04F3, 1, 2'b01, "R2 sp sqrt 2");
    chk(flags == 2'b01, "R8 flags inexact", 64'(flags), 64'd1);
    run_op(0, 64'h0000_0000_4110_0000, 0, 64'h4040_0000, 1, 2'b00, "R2 sp sqrt 9");
    run_op(0, 64'h0000_0000_3E80_0000, 0, 64'h3F00_0000, 1, 2'b00, "R2 sp sqrt 0.25");
    // R1 upper bits ignored in single mode
    run_op(0, 64'hDEAD_BEEF_4080_0000, 0, 64'h4000_0000, 1, 2'b00, "R1 sp upper ignored");
    // R3 zeros and flushed denormals
    run_op(0, 64'h0, 0, 64'h0, 1, 2'b00, "R3 sp +0");
    run_op(0, 64'h8000_0000, 0, 64'h8000_0000, 1, 2'b00, "R3 sp -0");
    run_op(0, 64'h0000_0001, 0, 64'h0, 1, 2'b00, "R3 sp +denorm");
    run_op(0, 64'h8000_0010, 0, 64'h8000_0000, 1, 2'b00, "R3 sp -denorm");
    // R4 infinities and negative normal
    run_op(0, 64'h7F80_0000, 0, 64'h7F80_0000, 1, 2'b00, "R4 sp +inf");
    run_op(0, 64'hFF80_0000, 0, 64'h7FBF_FFFF, 0, 2'b10, "R4 R6 sp -inf");
    chk(flags == 2'b11, "R8 flags sticky both", 64'(flags), 64'd3);
    run_op(0, 64'hC080_0000, 0, 64'h7FBF_FFFF, 0, 2'b10, "R4 R6 sp -4");
    // R5 NaNs
    run_op(0, 64'h7F80_0001, 0, 64'h7F80_0001, 1, 2'b00, "R5 sp qNaN");
    run_op(0, 64'h7FC0_0000, 0, 64'h7FBF_FFFF, 0, 2'b10, "R5 R6 sp sNaN");

    // R7 cause cleared on the accepting edge
    @(negedge clk);
    prec = 0; operand = 64'h4080_0000; inexact_en = 0; start = 1'b1;
    begin
      exp_t e;
      e.res = 64'h4000_0000; e.wr = 1; e.cs = 2'b00; e.tr = 0;
      e.lat = 9; e.st = cyc; e.tag = "R7 sp after invalid";
      exp_q.push_back(e);
    end
    @(negedge clk);
    start = 1'b0;
    chk(cause == 2'b00, "R7 cause cleared at start", 64'(cause), 64'd0);
    // R10 start while busy is ignored
    @(negedge clk);
    operand = 64'h4110_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 still busy", 64'(busy), 64'd1);
    do @(negedge clk); while (exp_q.size() != 0);
    repeat (12) @(negedge clk);
    chk(busy == 1'b0, "R10 ignored start left idle", 64'(busy), 64'd0);

    // R8 flag clear, with sticky retained beforehand
    chk(flags == 2'b11, "R8 flags held", 64'(flags), 64'd3);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk(flags == 2'b00, "R8 flags cleared", 64'(flags), 64'd0);

    // R9 trap on exact result when enabled
    run_op(0, 64'h4080_0000, 1, 64'h4000_0000, 1, 2'b00, "R9 sp trap exact");
    run_op(0, 64'hFF80_0000, 1, 64'h7FBF_FFFF, 0, 2'b10, "R9 sp trap invalid");

    // double precision (R1, R2)
    run_op(1, 64'h4030_0000_0000_0000, 0, 64'h4010_0000_0000_0000, 1, 2'b00, "R2 dp sqrt 16");
    run_op(1, 64'h4000_0000_0000_0000, 0, 64'h3FF6_A09E_667F_3BCD, 1, 2'b01, "R2 dp sqrt 2");
    run_op(1, 64'h4008_0000_0000_0000, 0, dsqrt(64'h4008_0000_0000_0000), 1, 2'b01, "R2 dp sqrt 3");
    run_op(1, 64'h4202_A05F_2000_0000, 0, dsqrt(64'h4202_A05F_2000_0000), 1, 2'b00, "R2 dp sqrt 1e10");
    run_op(1, 64'h3FD0_0000_0000_0000, 1, 64'h3FE0_0000_0000_0000, 1, 2'b00, "R1 R9 dp sqrt 0.25");
    run_op(1, 64'h8000_0000_0000_0000, 0, 64'h8000_0000_0000_0000, 1, 2'b00, "R3 dp -0");
    run_op(1, 64'h000F_0000_0000_0001, 0, 64'h0, 1, 2'b00, "R3 dp denorm");
    run_op(1, 64'h7FF0_0000_0000_0000, 0, 64'h7FF0_0000_0000_0000, 1, 2'b00, "R4 dp +inf");
    run_op(1, 64'hFFF0_0000_0000_0000, 0, 64'h7FF7_FFFF_FFFF_FFFF, 0, 2'b10, "R4 R6 dp -inf");
    run_op(1, 64'hBFF0_0000_0000_0000, 0, 64'h7FF7_FFFF_FFFF_FFFF, 0, 2'b10, "R4 R6 dp -1");
    run_op(1, 64'h7FF0_0000_0000_0001, 0, 64'h7FF0_0000_0000_0001, 1, 2'b00, "R5 dp qNaN");
    run_op(1, 64'h7FF8_0000_0000_0000, 0, 64'h7FF7_FFFF_FFFF_FFFF, 0, 2'b10, "R5 R6 dp sNaN");

    // R11 opcode match
    @(negedge clk); instr = 16'hF36D;
    @(negedge clk);
    chk(op_hit == 1'b1 && op_reg == 4'h3, "R11 match", 64'({op_hit, op_reg}), 64'h13);
    instr = 16'hFA6C;
    @(negedge clk);
    chk(op_hit == 1'b0 && op_reg == 4'hA, "R11 low byte mismatch", 64'({op_hit, op_reg}), 64'h0A);
    instr = 16'hE56D;
    @(negedge clk);
    chk(op_hit == 1'b0, "R11 top nibble mismatch", 64'(op_hit), 64'd0);

    finish_run();
  end
endmodule